// File: doc/BRIEF.md
# SPI NAND Single-Lane Command Engine

This block runs one complete SPI NAND command over a single-bit SPI link in clock mode 0. Each request names an opcode, up to three address bytes, a count of dummy bytes, a data direction and a data byte count. The engine steps through these in turn: opcode, address, dummy, then data. Any phase with a count of zero is skipped. The same engine therefore serves every command a NAND driver needs. A reset, write enable or write disable carries only the opcode. Block erase, page-to-cache read and program execute carry a 3-byte row address. Feature access carries a 1-byte register number and one data byte. Identification reads and cache reads add dummy bytes before a burst of input bytes. Program-load commands stream output data after a 2-byte column address.

Outgoing data bytes come from a valid/ready byte stream, and incoming bytes leave on a second stream. While a stream is not ready, the engine parks SCLK low at the byte boundary. The serial clock rate is the system clock divided by twice the `CLK_DIV` parameter. When the transaction ends, chip select rises and `done` pulses for one cycle.

Top module: `snand_cmd_engine`

## Requirements
- R1: Out of reset, chip select is high, SCLK and MOSI are low, done is low and the request port is ready.
- R2: After chip select falls, the bus carries 1 + address count + dummy count + data length bytes, in this order. The opcode comes first. The address bytes follow, taken from the low 8×count bits of the 24-bit address, most significant byte first. Each dummy byte is 0x00. The data bytes come last, and during a read each one is sent as 0x00.
- R3: Every byte moves most significant bit first. SCLK is low whenever chip select is high. MOSI changes only while SCLK is low. MISO is sampled at the rising SCLK edge.
- R4: In a write, each data byte is the next byte accepted on the transmit stream (valid and ready both high in one cycle). The engine holds SCLK low until that byte is offered.
- R5: In a read, each received byte appears on the receive stream. rx_valid and rx_data hold steady until rx_ready is seen. No further read byte is clocked in until the previous one has been taken.
- R6: A phase with a zero count is skipped. An opcode-only command ends right after the eighth bit.
- R7: done pulses for one cycle once chip select has risen. Chip select then stays high for at least 2 clocks. The request port is ready only when idle with no received byte pending.
- R8: A request presented while the port is not ready has no effect. The transaction in flight is unchanged and no extra transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_opcode | input | 8 | Command opcode |
| req_addr | input | 24 | Address; low bytes used per count |
| req_addr_bytes | input | 2 | Address byte count, 0 to 3 |
| req_dummy_bytes | input | DMY_W | Dummy byte count |
| req_write | input | 1 | 1 = data phase sends, 0 = receives |
| req_len | input | LEN_W | Data byte count |
| tx_data | input | 8 | Outgoing data byte |
| tx_valid | input | 1 | Outgoing byte offered |
| tx_ready | output | 1 | Engine takes the outgoing byte |
| rx_data | output | 8 | Received data byte |
| rx_valid | output | 1 | Received byte offered |
| rx_ready | input | 1 | Host takes the received byte |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
Several properties are checked on every cycle by assertions: the idle-low clock while deselected, MOSI held steady while SCLK is high, the single-cycle done pulse with chip select already high, the two-cycle deselect gap, and the receive stream holding its byte under back-pressure. The content and order of the serial stream are shown only by the bench's scenarios. This covers opcode, address byte order, dummy and data bytes, each phase being skipped at count zero, the mapping of MISO bits onto received bytes, and a request ignored mid-transaction. In those scenarios a bench-side device model captures every bit and replays known response bytes, under random stream gaps.

// File: rtl/snand_cmd_engine.sv
module snand_cmd_engine #(
  parameter int CLK_DIV = 2,
  parameter int LEN_W   = 12,
  parameter int DMY_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_opcode,
  input  logic [23:0]      req_addr,
  input  logic [1:0]       req_addr_bytes,
  input  logic [DMY_W-1:0] req_dummy_bytes,
  input  logic             req_write,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             done
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int CW0   = (LEN_W > DMY_W) ? LEN_W : DMY_W;
  localparam int CNT_W = (CW0 > 2) ? CW0 : 2;

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_NEXT, S_HOLD, S_GAP} st_t;
  typedef enum logic [1:0] {P_OP, P_ADDR, P_DMY, P_DATA} ph_t;

  st_t              st;
  ph_t              ph;
  logic [CNT_W-1:0] rem, next_cnt;
  logic [DIV_W-1:0] div;
  logic [2:0]       bitn;
  logic [7:0]       sreg, rsh, abyte, next_byte;
  logic [23:0]      addr_q;
  logic [1:0]       ab_q;
  logic [DMY_W-1:0] db_q;
  logic [LEN_W-1:0] len_q;
  logic             wr_q, gap, cs_q, sclk_q, done_q, rxv_q;
  logic [7:0]       rx_q;

  wire tick      = (div == DIV_W'(CLK_DIV - 1));
  wire timing    = (st == S_LO) || (st == S_HI) || (st == S_HOLD);
  wire data_slot = (ph == P_DATA) && (rem != '0);
  wire can_issue = (st == S_NEXT) && (rem != '0) &&
                   ((ph != P_DATA) || (wr_q ? tx_valid : !rxv_q));

  assign req_ready = (st == S_IDLE) && !rxv_q;
  assign tx_ready  = (st == S_NEXT) && data_slot && wr_q;
  assign rx_data   = rx_q;
  assign rx_valid  = rxv_q;
  assign cs_n      = cs_q;
  assign sclk      = sclk_q;
  assign mosi      = !cs_q && sreg[7];
  assign done      = done_q;

  always_comb begin
    case (rem[1:0])
      2'd3:    abyte = addr_q[23:16];
      2'd2:    abyte = addr_q[15:8];
      default: abyte = addr_q[7:0];
    endcase
    if (ph == P_ADDR)                next_byte = abyte;
    else if (ph == P_DATA && wr_q)   next_byte = tx_data;
    else                             next_byte = 8'h00;
    case (ph)
      P_OP:    next_cnt = CNT_W'(ab_q);
      P_ADDR:  next_cnt = CNT_W'(db_q);
      default: next_cnt = CNT_W'(len_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  ph <= P_OP;   rem <= '0;   div <= '0;  bitn <= '0;
      sreg <= '0;    rsh <= '0;    addr_q <= '0; ab_q <= '0; db_q <= '0;
      len_q <= '0;   wr_q <= 1'b0; gap <= 1'b0;  cs_q <= 1'b1; sclk_q <= 1'b0;
      done_q <= 1'b0; rxv_q <= 1'b0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      div    <= (timing && !tick) ? div + DIV_W'(1) : '0;
      if (rxv_q && rx_ready) rxv_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid && req_ready) begin
          addr_q <= req_addr;  ab_q <= req_addr_bytes; db_q <= req_dummy_bytes;
          len_q  <= req_len;   wr_q <= req_write;      sreg <= req_opcode;
          ph <= P_OP; rem <= '0; bitn <= '0; cs_q <= 1'b0; st <= S_LO;
        end
        S_LO: if (tick) begin
          sclk_q <= 1'b1;
          rsh    <= {rsh[6:0], miso};
          st     <= S_HI;
        end
        S_HI: if (tick) begin
          sclk_q <= 1'b0;
          if (bitn == 3'd7) begin
            bitn <= '0;
            if (ph == P_DATA && !wr_q) begin
              rx_q  <= rsh;
              rxv_q <= 1'b1;
            end
            st <= S_NEXT;
          end else begin
            bitn <= bitn + 3'd1;
            sreg <= {sreg[6:0], 1'b0};
            st   <= S_LO;
          end
        end
        S_NEXT: begin
          if (rem == '0) begin
            if (ph == P_DATA) st <= S_HOLD;
            else begin
              ph  <= ph_t'(ph + 2'd1);
              rem <= next_cnt;
            end
          end else if (can_issue) begin
            sreg <= next_byte;
            rem  <= rem - CNT_W'(1);
            st   <= S_LO;
          end
        end
        S_HOLD: if (tick) begin
          cs_q <= 1'b1; done_q <= 1'b1; gap <= 1'b0; st <= S_GAP;
        end
        S_GAP: begin
          gap <= 1'b1;
          if (gap) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snand_cmd_engine_chk.sv
module snand_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic       done,
  input logic       req_ready,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data
);
  AST_IDLE_CLK_LOW:  assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);  // R3
  AST_MOSI_HELD:     assert property (@(posedge clk) disable iff (!rst_n) sclk |-> $stable(mosi));  // R3
  AST_TX_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> (!sclk && !cs_n));  // R4
  AST_RX_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));  // R5
  AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);  // R7
  AST_DONE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) done |-> cs_n);  // R7
  AST_CS_GAP:        assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n ##1 cs_n);  // R7
  AST_READY_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (cs_n && !rx_valid));  // R7
endmodule

bind snand_cmd_engine snand_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .done(done),
  .req_ready(req_ready), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/tb_snand_cmd_engine.sv
module tb_snand_cmd_engine;
  localparam int LEN_W = 12;
  localparam int DMY_W = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, tx_valid = 0, rx_ready = 0, miso = 0;
  logic [7:0] req_opcode = 0, tx_data = 0;
  logic [23:0] req_addr = 0;
  logic [1:0] req_addr_bytes = 0;
  logic [DMY_W-1:0] req_dummy_bytes = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic req_ready, tx_ready, rx_valid, cs_n, sclk, mosi, done;
  logic [7:0] rx_data;

  always #2 clk = ~clk;

  snand_cmd_engine #(.CLK_DIV(2), .LEN_W(LEN_W), .DMY_W(DMY_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_addr(req_addr), .req_addr_bytes(req_addr_bytes),
    .req_dummy_bytes(req_dummy_bytes), .req_write(req_write), .req_len(req_len),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso), .done(done)
  );

  int n_chk = 0, n_fail = 0, txn_id = 0, nbits = 0;
  bit finished = 0;
  logic [7:0] cap [64];
  logic [7:0] wd [64];
  logic [7:0] got [64];
  logic [7:0] t_op; logic [23:0] t_addr; int t_ab, t_db, t_len; bit t_wr;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] resp_byte(int i);
    return 8'((i * 29) + (txn_id * 7) + 8'h5A);
  endfunction

  function automatic logic resp_bit(int n);
    logic [7:0] b;
    b = resp_byte(n >> 3);
    return b[7 - (n & 7)];
  endfunction

  function automatic logic [7:0] exp_mosi(int i);
    if (i == 0) return t_op;
    if (i < 1 + t_ab) return 8'(t_addr >> (8 * (t_ab - i)));
    if (i < 1 + t_ab + t_db) return 8'h00;
    return t_wr ? wd[i - 1 - t_ab - t_db] : 8'h00;
  endfunction

  // device model: captures MOSI on rising SCLK, updates MISO on falling SCLK
  initial begin
    logic last;
    last = 0;
    forever begin
      @(posedge sclk or negedge sclk or negedge cs_n);
      if (!cs_n) begin
        if (sclk && !last) begin
          if ((nbits >> 3) < 64) cap[nbits >> 3][7 - (nbits & 7)] = mosi;
          nbits++;
        end else if (!sclk && last) miso = resp_bit(nbits);
        else begin
          nbits = 0;
          miso  = resp_bit(0);
        end
      end
      last = sclk;
    end
  end

  task automatic run_txn(input logic [7:0] op, input logic [23:0] addr, input int ab,
                         input int db, input bit wr, input int len, input string tag,
                         input bit junk);
    int total, ntx, nrx, first_bad;
    t_op = op; t_addr = addr; t_ab = ab; t_db = db; t_wr = wr; t_len = len;
    txn_id++;
    for (int k = 0; k < len; k++) wd[k] = 8'($urandom);
    while (!req_ready) @(negedge clk);
    req_opcode = op; req_addr = addr; req_addr_bytes = 2'(ab);
    req_dummy_bytes = DMY_W'(db); req_write = wr; req_len = LEN_W'(len);
    req_valid = 1;
    @(negedge clk);
    if (junk) begin
      req_opcode = 8'hAA; req_addr_bytes = 2'd3; req_len = LEN_W'(5);
    end else req_valid = 0;
    ntx = 0; nrx = 0;
    fork
      begin
        while (wr && ntx < len) begin
          if ($urandom % 4 == 0) tx_valid = 0;
          else begin
            tx_valid = 1; tx_data = wd[ntx];
            if (tx_ready) ntx++;
          end
          @(negedge clk);
        end
        tx_valid = 0;
      end
      begin
        while (!wr && nrx < len) begin
          rx_ready = ($urandom % 3 != 0);
          if (rx_ready && rx_valid) begin got[nrx] = rx_data; nrx++; end
          @(negedge clk);
        end
        rx_ready = 0;
      end
      begin
        while (!done) @(negedge clk);
        chk(cs_n == 1, "R7", "cs_n at done", int'(cs_n), 1);
        req_valid = 0;
      end
    join
    total = 1 + ab + db + len;
    chk(nbits == 8 * total, (len == 0 || ab == 0) ? "R6" : "R2", {tag, " bit count"}, nbits, 8 * total);
    first_bad = -1;
    for (int i = 0; i < total && i < 64; i++)
      if (cap[i] !== exp_mosi(i) && first_bad < 0) first_bad = i;
    chk(first_bad < 0, "R2", {tag, " mosi byte"}, (first_bad < 0) ? 0 : int'(cap[first_bad]),
        (first_bad < 0) ? 0 : int'(exp_mosi(first_bad)));
    if (wr && len > 0) chk(ntx == len, "R4", {tag, " tx bytes taken"}, ntx, len);
    if (!wr && len > 0) begin
      first_bad = -1;
      for (int j = 0; j < len; j++)
        if (got[j] !== resp_byte(1 + ab + db + j) && first_bad < 0) first_bad = j;
      chk(first_bad < 0, "R5", {tag, " rx byte (R3 bit order)"},
          (first_bad < 0) ? 0 : int'(got[first_bad]),
          (first_bad < 0) ? 0 : int'(resp_byte(1 + ab + db + first_bad)));
    end
  endtask

  initial begin
    int dummy, saved;
    dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && mosi == 0, "R1", "bus idle", {cs_n, sclk, mosi}, 3'b100);
    chk(done == 0 && req_ready == 1, "R1", "done/ready", {done, req_ready}, 2'b01);

    run_txn(8'hFF, 24'h0, 0, 0, 0, 0, "R6 reset cmd", 0);
    run_txn(8'h06, 24'h0, 0, 0, 0, 0, "R6 wr enable", 0);
    run_txn(8'h0F, 24'hC0, 1, 0, 0, 1, "get feature", 0);
    run_txn(8'h1F, 24'hA0, 1, 0, 1, 1, "set feature", 0);
    run_txn(8'hD8, 24'h12_34_56, 3, 0, 0, 0, "R6 erase", 0);
    run_txn(8'h9F, 24'h0, 0, 1, 0, 6, "read id", 0);
    run_txn(8'h0B, 24'h0123, 2, 1, 0, 16, "cache read", 0);
    run_txn(8'h02, 24'h0456, 2, 0, 1, 20, "program load", 0);

    run_txn(8'h84, 24'h0789, 2, 0, 1, 3, "R8 busy request", 1);
    saved = nbits;
    repeat (20) @(negedge clk);
    chk(cs_n == 1 && nbits == saved, "R8", "no extra transaction", nbits, saved);

    for (int r = 0; r < 20; r++)
      run_txn(8'($urandom), 24'($urandom), int'($urandom % 4), int'($urandom % 4),
              1'($urandom), int'($urandom % 25), "random", 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule